// File: doc/BRIEF.md
# ATA Task File and Status Unit

This block is the device-side register file of an ATA disk. A host reaches it through eight byte-wide register slots and a separate 16-bit data port. It holds the sector count, the three address bytes and the device-select byte. Writing the command slot starts a command: identify-device, execute-diagnostic, flush-cache, or an abort for any other code. The block drives the status byte and an interrupt line that tell the host what to do next.

Identify-device opens a 256-word data-out phase. The words are computed in logic from two string parameters, a serial number and a firmware revision. Flush-cache keeps the unit busy until a media backend answers on a simple request/done pair. Reading the status slot acknowledges the interrupt.

Top module: `ata_taskfile`

## Requirements
- R1: After reset the status byte reads 0x40 (ready only), the error byte and device byte read 0x00, and `irq` is low.
- R2: Byte writes to slot 2 (sector count), slots 3, 4 and 5 (address low, mid, high) and slot 6 (device) read back unchanged from the same slot. Slot 1 reads the error byte and slot 0 reads 0x00.
- R3: Writing 0xEC to slot 7 enters a data-out phase of 256 words. Before every word the status reads 0x48 (DRQ bit 3 plus ready bit 6); each `data_rd` pulse consumes one word. After the last word the status reads 0x40.
- R4: In the identify data, words 10 to 19 carry the 20-character serial parameter and words 23 to 26 the 8-character revision parameter, two characters per word with the earlier character in the high byte. Word 85 reads 0x0020 (write cache enabled, bit 5). Every other word reads 0x0000.
- R5: Writing 0x90 to slot 7 clears bit 4 of the device byte (device 1 select) and keeps its other bits. It sets the error byte to 0x01, leaves status at 0x40 and raises `irq`.
- R6: Writing 0xE7 to slot 7 raises `flush_req`, and the status reads 0xC0 (busy bit 7 plus ready) until a `flush_done` pulse. On the cycle after that pulse `flush_req` is low, the status reads 0x40 and `irq` is high.
- R7: Any other command code sets the status to 0x41 (error bit 0), sets the error byte to 0x04 (abort, bit 2) and raises `irq`, without a data phase.
- R8: `irq` rises in the clock cycle a command completes. A read of slot 7 clears it on the next edge unless a completion lands on that same edge.
- R9: While busy, writes to slots 1 to 7, including new commands, are ignored.
- R10: Outside a data-out phase `data_rdata` reads 0x0000 and `data_rd` leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register slot 0 to 7 |
| reg_wr | input | 1 | Byte write strobe |
| reg_rd | input | 1 | Byte read strobe (slot 7 acknowledges interrupt) |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte of the addressed slot, combinational |
| data_rd | input | 1 | 16-bit data port read strobe |
| data_rdata | output | 16 | Current data-out word, combinational |
| irq | output | 1 | Interrupt request |
| flush_req | output | 1 | Flush pending toward the media backend |
| flush_done | input | 1 | Backend completion pulse |

## Verification
Read data is combinational, so a slot or data word is valid in the same cycle its strobe is presented. Every state change (command start, word advance, flush end, interrupt set or clear) is visible one edge after the strobe or `flush_done` that caused it. The driver raises each strobe for exactly one cycle and idles one cycle between operations. The monitor samples two nanoseconds after the falling edge, so every comparison sees the state left by the previous rising edge. Interrupt checks are ordered ahead of any status read, because that read clears the interrupt at the next edge.

// File: rtl/ata_taskfile.sv
module ata_taskfile #(
  parameter logic [159:0] SERIAL = "00000000000000000000",
  parameter logic [63:0]  FWREV  = "0.0     "
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        data_rd,
  output logic [15:0] data_rdata,
  output logic        irq,
  output logic        flush_req,
  input  logic        flush_done
);
  typedef enum logic [1:0] {S_IDLE, S_DOUT, S_FLUSH} st_t;

  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_DIAG  = 8'h90;
  localparam logic [7:0] OP_FLUSH = 8'hE7;

  st_t        st;
  logic [7:0] widx, nsect, lba_lo, lba_mid, lba_hi, devreg, errreg;
  logic       err_st, bsy, drq, cmd_wr;
  logic [7:0] status;

  assign bsy       = (st == S_FLUSH);
  assign drq       = (st == S_DOUT);
  assign flush_req = bsy;
  assign status    = {bsy, 1'b1, 1'b0, 1'b0, drq, 1'b0, 1'b0, err_st};
  assign cmd_wr    = reg_wr && (reg_addr == 3'd7) && !bsy;

  function automatic logic [15:0] id_word(input logic [7:0] i);
    int k;
    id_word = 16'h0000;
    if (i >= 8'd10 && i <= 8'd19) begin
      k = int'(i) - 10;
      id_word = {SERIAL[159-16*k -: 8], SERIAL[151-16*k -: 8]};
    end else if (i >= 8'd23 && i <= 8'd26) begin
      k = int'(i) - 23;
      id_word = {FWREV[63-16*k -: 8], FWREV[55-16*k -: 8]};
    end else if (i == 8'd85) begin
      id_word = 16'h0020;
    end
  endfunction

  assign data_rdata = drq ? id_word(widx) : 16'h0000;

  always_comb begin
    case (reg_addr)
      3'd1:    reg_rdata = errreg;
      3'd2:    reg_rdata = nsect;
      3'd3:    reg_rdata = lba_lo;
      3'd4:    reg_rdata = lba_mid;
      3'd5:    reg_rdata = lba_hi;
      3'd6:    reg_rdata = devreg;
      3'd7:    reg_rdata = status;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      widx    <= '0;
      nsect   <= '0;
      lba_lo  <= '0;
      lba_mid <= '0;
      lba_hi  <= '0;
      devreg  <= '0;
      errreg  <= '0;
      err_st  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (reg_rd && reg_addr == 3'd7) irq <= 1'b0;

      if (reg_wr && !bsy) begin
        case (reg_addr)
          3'd2: nsect   <= reg_wdata;
          3'd3: lba_lo  <= reg_wdata;
          3'd4: lba_mid <= reg_wdata;
          3'd5: lba_hi  <= reg_wdata;
          3'd6: devreg  <= reg_wdata;
          default: ;
        endcase
      end

      if (data_rd && drq) begin
        widx <= widx + 8'd1;
        if (widx == 8'hFF) st <= S_IDLE;
      end

      if (cmd_wr) begin
        case (reg_wdata)
          OP_IDENT: begin
            st <= S_DOUT; widx <= '0; errreg <= '0; err_st <= 1'b0; irq <= 1'b1;
          end
          OP_DIAG: begin
            st <= S_IDLE; devreg[4] <= 1'b0; errreg <= 8'h01; err_st <= 1'b0; irq <= 1'b1;
          end
          OP_FLUSH: begin
            st <= S_FLUSH; errreg <= '0; err_st <= 1'b0;
          end
          default: begin
            st <= S_IDLE; errreg <= 8'h04; err_st <= 1'b1; irq <= 1'b1;
          end
        endcase
      end

      if (bsy && flush_done) begin
        st  <= S_IDLE;
        irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic       irq,
  input logic       flush_req,
  input logic       flush_done,
  input logic       bsy,
  input logic       drq,
  input logic       err_st
);
  logic cmd7;
  assign cmd7 = reg_wr && reg_addr == 3'd7;

  // R3
  drq_bsy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq));

  // R6
  flush_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_req) |-> $past(cmd7 && reg_wdata == 8'hE7));

  // R6
  flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && flush_done |=> !flush_req && irq);

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd7 && !bsy && reg_wdata != 8'hEC && reg_wdata != 8'h90 && reg_wdata != 8'hE7
    |=> err_st && irq && !drq && !bsy);

  // R8
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 3'd7 && !cmd7 && !(flush_req && flush_done) |=> !irq);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsy && cmd7 && !flush_done |=> bsy);
endmodule

bind ata_taskfile ata_taskfile_chk u_chk (.*);

// File: tb/tb_ata_taskfile.sv
`timescale 1ns/1ps
module tb_ata_taskfile;
  localparam logic [159:0] SER = "TF-SERIAL-00042     ";
  localparam logic [63:0]  REV = "REV 1.07";

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0, data_rd = 0, flush_done = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [15:0] data_rdata;
  logic irq, flush_req;

  always #4 clk = ~clk;

  ata_taskfile #(.SERIAL(SER), .FWREV(REV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_rd(data_rd),
    .data_rdata(data_rdata), .irq(irq), .flush_req(flush_req), .flush_done(flush_done));

  typedef struct { int kind; logic [15:0] exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  logic go = 0;

  always @(negedge clk) begin
    #2;
    if (go && q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {8'h00, reg_rdata};
        1: act = data_rdata;
        2: act = {15'd0, irq};
        default: act = {15'd0, flush_req};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); reg_addr = a; reg_rd = 1; go = 1;
    q.push_back('{0, {8'h00, e}, tag});
    @(negedge clk); reg_rd = 0; go = 0;
  endtask

  task automatic rdw(input logic [15:0] e, input string tag);
    @(negedge clk); data_rd = 1; go = 1;
    q.push_back('{1, e, tag});
    @(negedge clk); data_rd = 0; go = 0;
  endtask

  task automatic peek(input int k, input logic e, input string tag);
    @(negedge clk); go = 1;
    q.push_back('{k, {15'd0, e}, tag});
    @(negedge clk); go = 0;
  endtask

  function automatic logic [15:0] exp_word(input int i);
    if (i >= 10 && i <= 19) return {SER[159-16*(i-10) -: 8], SER[151-16*(i-10) -: 8]};
    if (i >= 23 && i <= 26) return {REV[63-16*(i-23) -: 8], REV[55-16*(i-23) -: 8]};
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  logic done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(3'd7, 8'h40, "R1 status");
    rd(3'd1, 8'h00, "R1 error");
    rd(3'd6, 8'h00, "R1 device");
    peek(2, 1'b0, "R1 irq");
    // R2
    wr(3'd2, 8'h5A); wr(3'd3, 8'h11); wr(3'd4, 8'h22); wr(3'd5, 8'h33); wr(3'd6, 8'h50);
    rd(3'd2, 8'h5A, "R2 nsect");
    rd(3'd3, 8'h11, "R2 lba lo");
    rd(3'd4, 8'h22, "R2 lba mid");
    rd(3'd5, 8'h33, "R2 lba hi");
    rd(3'd6, 8'h50, "R2 device");
    rd(3'd0, 8'h00, "R2 slot0");
    // R10
    rdw(16'h0000, "R10 data outside phase");
    rd(3'd7, 8'h40, "R10 status after stray read");
    // R5
    wr(3'd7, 8'h90);
    peek(2, 1'b1, "R5 irq");
    rd(3'd6, 8'h40, "R5 device bit cleared");
    rd(3'd1, 8'h01, "R5 error code");
    rd(3'd7, 8'h40, "R5 status");
    // R8
    peek(2, 1'b0, "R8 irq cleared by status read");
    // R7
    wr(3'd7, 8'h20);
    peek(2, 1'b1, "R7 irq");
    rd(3'd1, 8'h04, "R7 abort error");
    rd(3'd7, 8'h41, "R7 status");
    rdw(16'h0000, "R7 no data phase");
    // R3 R4
    wr(3'd7, 8'hEC);
    peek(2, 1'b1, "R3 irq");
    for (int i = 0; i < 256; i++) begin
      rd(3'd7, 8'h48, "R3 status before word");
      rdw(exp_word(i), "R4 identify word");
    end
    rd(3'd7, 8'h40, "R3 status after last word");
    rdw(16'h0000, "R10 data after phase");
    rd(3'd7, 8'h40, "R10 status unchanged");
    // R6 R9
    wr(3'd7, 8'hE7);
    peek(3, 1'b1, "R6 flush_req");
    rd(3'd7, 8'hC0, "R6 busy status");
    wr(3'd7, 8'hEC);
    wr(3'd2, 8'hA5);
    rd(3'd7, 8'hC0, "R9 command ignored while busy");
    peek(3, 1'b1, "R9 flush still pending");
    peek(2, 1'b0, "R6 no irq while busy");
    @(negedge clk); flush_done = 1;
    @(negedge clk); flush_done = 0;
    peek(3, 1'b0, "R6 flush_req dropped");
    peek(2, 1'b1, "R6 irq on completion");
    rd(3'd7, 8'h40, "R6 status after flush");
    rd(3'd2, 8'h5A, "R9 nsect write ignored while busy");
    peek(2, 1'b0, "R8 irq cleared");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule